// File: doc/BRIEF.md
# SMT Commit Thread Arbiter

This block picks the hardware thread that may retire its reorder-buffer head in the current commit slot of a multithreaded core. For every thread it takes a lifecycle status, a reorder-buffer empty flag, a head-ready flag and the sequence number of the head instruction. From these it returns a grant flag and a thread index, or no grant. The grant is combinational, so a commit loop can query the arbiter several times within one cycle.

A static policy input selects one of three selection rules:

- **Round robin** walks a registered priority list of thread indices. When the caller consumes a grant, the granted thread moves to the tail of that list.
- **Oldest-ready** picks the eligible thread whose head has the smallest sequence number.
- **Aggressive** uses exactly the same rule as oldest-ready.

With one thread the block reduces to a status gate.

Top module: `commit_thread_arb`

## Requirements
- R1: The 2-bit policy code selects the rule: 0 aggressive, 1 round robin, 2 oldest-ready. Code 3 behaves as oldest-ready.
- R2: With NUM_THREADS = 1, thread 0 is granted whenever its status is Idle, Running or FetchTrapPending. Otherwise there is no grant. The empty and ready flags are ignored in this case.
- R3: In round robin, the grant goes to the first thread in priority-list order whose status is Idle or Running and whose head is ready. The empty flag is not consulted.
- R4: When a round-robin grant is consumed (`grant_take_i` high at a clock edge while `grant_valid_o` is high), the granted thread is removed from its list position. It is appended at the tail, and all other entries keep their relative order.
- R5: The priority list is unchanged in three cases: `grant_take_i` is low, there is no grant, or the policy is not round robin.
- R6: After reset the priority list holds thread indices in ascending order, with thread 0 first.
- R7: Under oldest-ready and aggressive, a thread is eligible only if three conditions all hold:
  - its reorder buffer is non-empty;
  - its status is Idle, Running or FetchTrapPending;
  - its head is ready.
- R8: Under oldest-ready and aggressive, the eligible thread with the smallest head sequence number is granted. A tie goes to the lower thread index.
- R9: With no eligible thread, `grant_valid_o` is 0 and `grant_tid_o` is 0.
- R10: Status is a 3-bit code per thread, where thread t occupies bits [3t+2:3t]. The codes are Idle=0, Running=1, ROBSquashing=2, TrapPending=3 and FetchTrapPending=4. Codes 5 to 7 are never eligible.
- R11: The grant outputs follow the inputs within the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Selection policy code |
| status_i | input | 3*NUM_THREADS | Per-thread status codes |
| rob_empty_i | input | NUM_THREADS | Per-thread reorder buffer empty |
| head_ready_i | input | NUM_THREADS | Per-thread head ready to commit |
| head_seq_i | input | SEQ_W*NUM_THREADS | Per-thread head sequence number |
| grant_take_i | input | 1 | Caller consumes the current grant |
| grant_valid_o | output | 1 | A thread is granted |
| grant_tid_o | output | TID_W | Granted thread index |

## Verification
The only hidden state is the round-robin priority list. A corrupted entry shows up at the ports on the first round-robin query in which several threads are eligible: either the wrong thread is granted, or one thread is granted twice before the others have had a turn. The bench therefore tracks the list with its own model and compares every grant against it. A fault in the rotation is then caught one edge after a consumed grant.

The oldest-ready path has no state, so any selection error is visible in the same cycle as the inputs that expose it. Ties and fully ineligible mixes are driven on purpose to expose it.

// File: rtl/commit_arb_pkg.sv
package commit_arb_pkg;
  typedef enum logic [2:0] {
    TS_IDLE       = 3'd0,
    TS_RUNNING    = 3'd1,
    TS_ROB_SQUASH = 3'd2,
    TS_TRAP_PEND  = 3'd3,
    TS_FETCH_TRAP = 3'd4
  } thr_status_e;

  typedef enum logic [1:0] {
    POL_AGGRESSIVE = 2'd0,
    POL_ROUND_ROBIN = 2'd1,
    POL_OLDEST     = 2'd2,
    POL_SPARE      = 2'd3
  } arb_policy_e;

  localparam int unsigned STATUS_W = 3;

  function automatic logic st_rr_ok(input logic [2:0] st);
    return (st == TS_IDLE) || (st == TS_RUNNING);
  endfunction

  function automatic logic st_old_ok(input logic [2:0] st);
    return (st == TS_IDLE) || (st == TS_RUNNING) || (st == TS_FETCH_TRAP);
  endfunction
endpackage

// File: rtl/commit_arb_elig.sv
module commit_arb_elig
  import commit_arb_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4
) (
  input  logic [STATUS_W*NUM_THREADS-1:0] status_i,
  input  logic [NUM_THREADS-1:0]          rob_empty_i,
  input  logic [NUM_THREADS-1:0]          head_ready_i,
  output logic [NUM_THREADS-1:0]          rr_elig_o,
  output logic [NUM_THREADS-1:0]          old_elig_o,
  output logic [NUM_THREADS-1:0]          solo_elig_o
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [STATUS_W-1:0] st;
    assign st             = status_i[t*STATUS_W +: STATUS_W];
    assign rr_elig_o[t]   = st_rr_ok(st) && head_ready_i[t];
    assign old_elig_o[t]  = st_old_ok(st) && head_ready_i[t] && !rob_empty_i[t];
    assign solo_elig_o[t] = st_old_ok(st);
  end
endmodule

// File: rtl/commit_arb_oldest.sv
module commit_arb_oldest #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned SEQ_W       = 16,
  localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic [NUM_THREADS-1:0]       elig_i,
  input  logic [SEQ_W*NUM_THREADS-1:0] seq_i,
  output logic                         valid_o,
  output logic [TID_W-1:0]             tid_o
);
  logic [SEQ_W-1:0] best_seq;

  always_comb begin
    valid_o  = 1'b0;
    tid_o    = '0;
    best_seq = '0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      // strict compare keeps the lower index on a tie
      if (elig_i[k] && (!valid_o || seq_i[k*SEQ_W +: SEQ_W] < best_seq)) begin
        valid_o  = 1'b1;
        tid_o    = TID_W'(k);
        best_seq = seq_i[k*SEQ_W +: SEQ_W];
      end
    end
  end
endmodule

// File: rtl/commit_arb_rr.sv
module commit_arb_rr #(
  parameter int unsigned NUM_THREADS = 4,
  localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_THREADS-1:0] elig_i,
  input  logic                   advance_i,
  output logic                   valid_o,
  output logic [TID_W-1:0]       tid_o
);
  logic [NUM_THREADS-1:0][TID_W-1:0] prio_q, prio_d;
  logic [TID_W-1:0] pos;

  always_comb begin
    valid_o = 1'b0;
    pos     = '0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      if (!valid_o && elig_i[prio_q[k]]) begin
        valid_o = 1'b1;
        pos     = TID_W'(k);
      end
    end
    tid_o = prio_q[pos];
  end

  always_comb begin
    prio_d = prio_q;
    if (advance_i && valid_o) begin
      for (int k = 0; k < NUM_THREADS - 1; k++) begin
        if (TID_W'(k) >= pos) prio_d[k] = prio_q[k+1];
      end
      prio_d[NUM_THREADS-1] = prio_q[pos];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_THREADS; k++) prio_q[k] <= TID_W'(k);
    end else begin
      prio_q <= prio_d;
    end
  end
endmodule

// File: rtl/commit_thread_arb.sv
module commit_thread_arb
  import commit_arb_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned SEQ_W       = 16,
  localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [1:0]                      policy_i,
  input  logic [STATUS_W*NUM_THREADS-1:0] status_i,
  input  logic [NUM_THREADS-1:0]          rob_empty_i,
  input  logic [NUM_THREADS-1:0]          head_ready_i,
  input  logic [SEQ_W*NUM_THREADS-1:0]    head_seq_i,
  input  logic                            grant_take_i,
  output logic                            grant_valid_o,
  output logic [TID_W-1:0]                grant_tid_o
);
  logic [NUM_THREADS-1:0] rr_elig, old_elig, solo_elig;

  commit_arb_elig #(.NUM_THREADS(NUM_THREADS)) u_elig (
    .status_i    (status_i),
    .rob_empty_i (rob_empty_i),
    .head_ready_i(head_ready_i),
    .rr_elig_o   (rr_elig),
    .old_elig_o  (old_elig),
    .solo_elig_o (solo_elig)
  );

  if (NUM_THREADS == 1) begin : g_solo
    logic unused_ok;
    assign unused_ok     = ^{rr_elig, old_elig, policy_i, head_seq_i, grant_take_i, clk_i, rst_ni};
    assign grant_valid_o = solo_elig[0];
    assign grant_tid_o   = '0;
  end else begin : g_multi
    logic             is_rr;
    logic             rr_valid, old_valid;
    logic [TID_W-1:0] rr_tid, old_tid;
    logic             unused_ok;

    assign is_rr     = (policy_i == POL_ROUND_ROBIN);
    assign unused_ok = ^solo_elig;

    commit_arb_rr #(.NUM_THREADS(NUM_THREADS)) u_rr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .elig_i   (rr_elig),
      .advance_i(is_rr && grant_take_i),
      .valid_o  (rr_valid),
      .tid_o    (rr_tid)
    );

    commit_arb_oldest #(.NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W)) u_old (
      .elig_i (old_elig),
      .seq_i  (head_seq_i),
      .valid_o(old_valid),
      .tid_o  (old_tid)
    );

    // aggressive and the spare code share the oldest-ready path
    assign grant_valid_o = is_rr ? rr_valid : old_valid;
    assign grant_tid_o   = !grant_valid_o ? '0 : (is_rr ? rr_tid : old_tid);
  end
endmodule

// File: rtl/commit_thread_arb_chk.sv
module commit_thread_arb_chk #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned SEQ_W       = 16,
  localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [1:0]                   policy_i,
  input logic [3*NUM_THREADS-1:0]     status_i,
  input logic [NUM_THREADS-1:0]       rob_empty_i,
  input logic [NUM_THREADS-1:0]       head_ready_i,
  input logic [SEQ_W*NUM_THREADS-1:0] head_seq_i,
  input logic                         grant_take_i,
  input logic                         grant_valid_o,
  input logic [TID_W-1:0]             grant_tid_o
);
  logic [2:0]       g_st;
  logic [SEQ_W-1:0] g_seq;
  logic             older_exists;
  logic             any_open;
  int               rr_cnt;

  always_comb begin
    g_st         = status_i[grant_tid_o*3 +: 3];
    g_seq        = head_seq_i[grant_tid_o*SEQ_W +: SEQ_W];
    older_exists = 1'b0;
    any_open     = 1'b0;
    rr_cnt       = 0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      if (!rob_empty_i[k] && head_ready_i[k] &&
          (status_i[k*3 +: 3] <= 3'd1 || status_i[k*3 +: 3] == 3'd4)) begin
        any_open = 1'b1;
        if (head_seq_i[k*SEQ_W +: SEQ_W] < g_seq) older_exists = 1'b1;
      end
      if (head_ready_i[k] && status_i[k*3 +: 3] <= 3'd1) rr_cnt++;
    end
  end

  AST_TID_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> (int'(grant_tid_o) < NUM_THREADS)); // R9

  AST_NO_GRANT_TID_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_valid_o |-> (grant_tid_o == '0)); // R9

  if (NUM_THREADS == 1) begin : g_solo_chk
    AST_SOLO_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_valid_o == (g_st <= 3'd1 || g_st == 3'd4)); // R2
  end else begin : g_multi_chk
    AST_GRANT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_valid_o |-> head_ready_i[grant_tid_o]); // R3
    AST_GRANT_STATUS_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_valid_o |-> (g_st <= 3'd1 || g_st == 3'd4)); // R10
    AST_OLDEST_IS_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_valid_o && policy_i != 2'd1) |-> (!older_exists && !rob_empty_i[grant_tid_o])); // R8
    AST_OLDEST_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (policy_i != 2'd1 && !any_open) |-> !grant_valid_o); // R7
    AST_RR_ROTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (policy_i == 2'd1 && grant_valid_o && grant_take_i && rr_cnt > 1) |=>
      (!($stable(status_i) && $stable(head_ready_i) && $stable(policy_i)) ||
       grant_tid_o != $past(grant_tid_o))); // R4
    AST_HOLD_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !grant_take_i |=>
      (!($stable(status_i) && $stable(head_ready_i) && $stable(policy_i) &&
         $stable(rob_empty_i) && $stable(head_seq_i)) ||
       ($stable(grant_tid_o) && $stable(grant_valid_o)))); // R5
  end
endmodule

bind commit_thread_arb commit_thread_arb_chk #(
  .NUM_THREADS(NUM_THREADS),
  .SEQ_W      (SEQ_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .policy_i     (policy_i),
  .status_i     (status_i),
  .rob_empty_i  (rob_empty_i),
  .head_ready_i (head_ready_i),
  .head_seq_i   (head_seq_i),
  .grant_take_i (grant_take_i),
  .grant_valid_o(grant_valid_o),
  .grant_tid_o  (grant_tid_o)
);

// File: tb/tb_commit_thread_arb.sv
`timescale 1ns/1ps
module tb_commit_thread_arb;
  localparam int NT = 4;
  localparam int SW = 16;
  localparam int TW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    policy_i = 2'd1;
  logic [3*NT-1:0] status_i = '0;
  logic [NT-1:0] rob_empty_i = '0;
  logic [NT-1:0] head_ready_i = '0;
  logic [SW*NT-1:0] head_seq_i = '0;
  logic          grant_take_i = 1'b0;
  logic          grant_valid_o;
  logic [TW-1:0] grant_tid_o;

  logic [2:0] s_status = '0;
  logic       s_empty = 1'b0, s_ready = 1'b0;
  logic       s_valid;
  logic       s_tid;

  int n_chk = 0;
  int n_fail = 0;
  int list_m[NT];

  always #2.5 clk_i = ~clk_i;

  commit_thread_arb #(.NUM_THREADS(NT), .SEQ_W(SW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .policy_i(policy_i), .status_i(status_i),
    .rob_empty_i(rob_empty_i), .head_ready_i(head_ready_i), .head_seq_i(head_seq_i),
    .grant_take_i(grant_take_i), .grant_valid_o(grant_valid_o), .grant_tid_o(grant_tid_o));

  commit_thread_arb #(.NUM_THREADS(1), .SEQ_W(SW)) dut_single (
    .clk_i(clk_i), .rst_ni(rst_ni), .policy_i(policy_i), .status_i(s_status),
    .rob_empty_i(s_empty), .head_ready_i(s_ready), .head_seq_i(head_seq_i[SW-1:0]),
    .grant_take_i(grant_take_i), .grant_valid_o(s_valid), .grant_tid_o(s_tid));

  function automatic int st_of(int t);
    return int'(status_i[t*3 +: 3]);
  endfunction

  function automatic void expect_grant(output bit v, output int t);
    int best;
    v = 0; t = 0; best = 0;
    if (policy_i == 2'd1) begin
      for (int k = 0; k < NT; k++) begin
        int th = list_m[k];
        if (!v && head_ready_i[th] && (st_of(th) == 0 || st_of(th) == 1)) begin
          v = 1; t = th;
        end
      end
    end else begin
      for (int k = 0; k < NT; k++) begin
        int s = st_of(k);
        int q = int'(head_seq_i[k*SW +: SW]);
        if (!rob_empty_i[k] && head_ready_i[k] && (s == 0 || s == 1 || s == 4) &&
            (!v || q < best)) begin
          v = 1; t = k; best = q;
        end
      end
    end
  endfunction

  task automatic check_main(string req);
    bit ev; int et;
    expect_grant(ev, et);
    n_chk++;
    if (grant_valid_o !== ev || int'(grant_tid_o) !== et) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
               req, grant_valid_o, grant_tid_o, ev, et);
    end
  endtask

  task automatic rotate_model();
    bit ev; int et; int pos;
    expect_grant(ev, et);
    if (policy_i != 2'd1 || !ev || !grant_take_i) return;
    pos = 0;
    for (int k = 0; k < NT; k++) if (list_m[k] == et) pos = k;
    for (int k = 0; k < NT - 1; k++) if (k >= pos) list_m[k] = list_m[k+1];
    list_m[NT-1] = et;
  endtask

  task automatic set_thr(int t, int st, bit emp, bit rdy, int seq);
    status_i[t*3 +: 3]      = 3'(st);
    rob_empty_i[t]          = emp;
    head_ready_i[t]         = rdy;
    head_seq_i[t*SW +: SW]  = SW'(seq);
  endtask

  // one cycle: drive at negedge, check, let the next posedge apply any take
  task automatic step(string req);
    #1;
    check_main(req);
    rotate_model();
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < NT; k++) list_m[k] = k;
    for (int k = 0; k < NT; k++) set_thr(k, 1, 0, 1, 100);
    repeat (3) @(negedge clk_i);
    // R6: reset order while held in reset
    step("R6 reset list ascending");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4 directed rotation 0,1,2,3,0
    grant_take_i = 1'b1;
    for (int i = 0; i < 5; i++) step("R4 rotation sequence");
    // R5 no take holds
    grant_take_i = 1'b0;
    for (int i = 0; i < 3; i++) step("R5 hold without take");
    // R3 ready required, empty ignored
    set_thr(1, 1, 1, 1, 100);
    head_ready_i = 4'b0010;
    step("R3 empty flag ignored");
    set_thr(1, 4, 0, 1, 100);
    step("R10 FetchTrapPending not eligible in rr");
    // R9 nothing eligible
    head_ready_i = '0;
    step("R9 no grant rr");
    // R5 take with policy oldest leaves list
    policy_i = 2'd2;
    grant_take_i = 1'b1;
    for (int k = 0; k < NT; k++) set_thr(k, 1, 0, 1, 50 + k);
    step("R1 oldest policy");
    step("R5 take under oldest");
    policy_i = 2'd1;
    step("R5 list unchanged after oldest takes");
    grant_take_i = 1'b0;
    // R8 tie lower index
    policy_i = 2'd2;
    set_thr(0, 2, 0, 1, 1);
    set_thr(1, 1, 0, 1, 7);
    set_thr(2, 0, 0, 1, 9);
    set_thr(3, 4, 0, 1, 7);
    step("R8 tie to lower index");
    set_thr(1, 1, 1, 1, 7);
    step("R7 empty excluded");
    set_thr(3, 3, 0, 1, 7);
    set_thr(2, 5, 0, 1, 9);
    step("R9 no grant oldest");
    policy_i = 2'd0;
    set_thr(2, 0, 0, 1, 3);
    step("R10 aggressive matches oldest");
    policy_i = 2'd3;
    step("R1 spare code as oldest");

    // R2 single thread
    for (int st = 0; st < 8; st++) begin
      s_status = 3'(st);
      s_empty  = st[0];
      s_ready  = st[1];
      #1;
      n_chk++;
      if (s_valid !== (st == 0 || st == 1 || st == 4) || s_tid !== 1'b0) begin
        n_fail++;
        $display("FAIL R2 single thread status %0d: got valid=%0b tid=%0b, expected valid=%0b tid=0",
                 st, s_valid, s_tid, (st == 0 || st == 1 || st == 4));
      end
      @(negedge clk_i);
    end

    // random mix
    for (int i = 0; i < 3000; i++) begin
      policy_i = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) != 0) policy_i = 2'd1 + 2'($urandom_range(0, 1));
      for (int k = 0; k < NT; k++)
        set_thr(k, ($urandom_range(0, 3) == 0) ? $urandom_range(0, 7) : $urandom_range(0, 1),
                $urandom_range(0, 4) == 0, $urandom_range(0, 3) != 0, $urandom_range(0, 7));
      grant_take_i = $urandom_range(0, 1);
      step("R11 random R3 R8 same-cycle grant");
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule